// File: doc/BRIEF.md
# PHY Power-Up and Calibration Sequencer

This block brings up a storage-interface PHY with no software involved. A one-cycle start pulse samples two inputs: the requested output drive impedance in ohms and the interface clock frequency in hertz. The block turns these into a 3-bit drive code and a 2-bit frequency band code. It then drives a fixed series of masked register writes onto a simple single-master write/read bus. The upper half of each 32-bit write word is a per-bit write enable for the lower half. So the PHY register keeps every field whose enable bit is clear.

Between the writes the block inserts the settling waits that the PHY needs. It polls a status register for calibration completion and then for DLL lock. Each poll has its own retry limit and its own gap between attempts. If a poll runs out of attempts, the block sets a sticky timeout flag and carries on with the sequence. The `done` output pulses for one cycle when the sequence ends. The timeout flags keep their values until the next accepted start. All waits are counted in clock cycles from a cycles-per-microsecond parameter, so a simulation can shorten them.

Top module: `phy_bringup_seq`

## Requirements
- R1: Every bus write is masked. Bit N+16 of `bus_wdata` enables data bit N. No write carries a data bit set to 1 whose enable bit is 0.
- R2: The drive code is written to bits [6:4] of the register at offset 0x18, with enable bits [22:20]. The impedance maps as follows: 33→1, 40→4, 50→0, 66→2, 100→3, and any other value→0.
- R3: The band code is written to bits [13:12] of the register at offset 0x00, with enable bits [29:28]. Frequency 0 gives 0. Below 75,000,000 gives 1, below 125,000,000 gives 2, below 175,000,000 gives 3, and anything higher gives 0.
- R4: A run issues exactly seven writes, in this order:
  - offset 0x18: drive code;
  - 0x00: 0x08000800 (tap delay enable, bit 11);
  - 0x00: 0x07800200 (tap select 4 in bits [10:7]);
  - 0x18: 0x00030000 (power-down-bar bit 0 and DLL enable bit 1 both cleared);
  - 0x18: 0x00010001 (power-down-bar set);
  - 0x00: band code;
  - 0x18: 0x00020002 (DLL enable set).
- R5: The power-down-bar set write comes at least PD_WAIT_US microseconds after the write that clears power-down-bar and DLL enable.
- R6: After power-up the block reads offset 0x20 and tests bit 6 (calibration done). It stops at the first read with bit 6 set, or after CAL_TRIES reads. Successive reads are at least CAL_GAP_US apart. `cal_timeout` is set when every read fails.
- R7: After the DLL enable write, the block polls bit 5 (DLL ready) of offset 0x20 in the same way, with DLL_TRIES attempts at least DLL_GAP_US apart. It does this only when the sampled frequency is nonzero. `dll_timeout` is set when every attempt fails. With frequency 0 there are no DLL reads.
- R8: `done` is high for exactly one cycle at the end of every run, even one that timed out. Both timeout flags keep their values while idle and are cleared by an accepted start.
- R9: A start pulse while `busy` is high is ignored. The run in progress keeps its sampled inputs, its flags and its single `done` pulse.
- R10: After reset the block is idle: `busy`, `done`, `bus_wr`, `bus_rd` and both flags are 0.
- R11: `bus_wr` and `bus_rd` are never high together. A read returns its data in `bus_rdata` during the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the bring-up sequence |
| imp_ohm | input | IMP_W | Requested drive impedance in ohms, sampled at start |
| freq_hz | input | FREQ_W | Interface clock frequency in Hz, sampled at start |
| bus_wr | output | 1 | Write strobe, one cycle per write |
| bus_rd | output | 1 | Read strobe, one cycle per read |
| bus_addr | output | ADDR_W | Register byte offset |
| bus_wdata | output | 32 | Masked write word: enables in [31:16], data in [15:0] |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_rd |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| cal_timeout | output | 1 | Calibration never reported done |
| dll_timeout | output | 1 | DLL never reported ready |

## Verification
The bench builds the block with CYC_PER_US=2, PD_WAIT_US=3, CAL_GAP_US=10 and DLL_GAP_US=20, keeping five attempts for each poll. At these values a worst-case run takes a few hundred cycles. That lets the bench sweep every frequency band edge, each listed impedance and several unlisted ones, and every poll outcome: success on attempts 1 to 5 and no success at all, for both calibration and DLL. The scaled waits are short enough to measure exactly at the bus, so the minimum power-up delay and the poll gaps are checked against their cycle counts. The status model sets the other poll's bit as noise, so testing the wrong bit is caught.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WR_DRV,
      ST_WR_TAPEN,
      ST_WR_TAPSEL,
      ST_WR_PDOFF,
      ST_WAIT_PD,
      ST_WR_PDON,
      ST_CAL_RD,
      ST_CAL_CHK,
      ST_CAL_GAP,
      ST_WR_BAND,
      ST_WR_DLLEN,
      ST_DLL_RD,
      ST_DLL_CHK,
      ST_DLL_GAP,
      ST_FIN
   } seq_state_e;

   // register byte offsets decoded by the PHY
   localparam logic [7:0] OFS_CTRL_A = 8'h00;
   localparam logic [7:0] OFS_CTRL_B = 8'h18;
   localparam logic [7:0] OFS_STAT   = 8'h20;

   // status bit positions
   localparam int STAT_CAL_BIT = 6;
   localparam int STAT_DLL_BIT = 5;

   // fixed masked words
   localparam logic [31:0] WD_TAP_EN   = 32'h0800_0800;
   localparam logic [31:0] WD_TAP_SEL4 = 32'h0780_0200;
   localparam logic [31:0] WD_PD_DLL_0 = 32'h0003_0000;
   localparam logic [31:0] WD_PD_ON    = 32'h0001_0001;
   localparam logic [31:0] WD_DLL_ON   = 32'h0002_0002;
   localparam logic [31:0] WM_DRV      = 32'h0070_0000;
   localparam logic [31:0] WM_BAND     = 32'h3000_0000;

endpackage

// File: rtl/phy_code_map.sv
module phy_code_map #(
   parameter int IMP_W  = 8,
   parameter int FREQ_W = 32
) (
   input  logic [IMP_W-1:0]  imp_ohm,
   input  logic [FREQ_W-1:0] freq_hz,
   output logic [2:0]        drv_code,
   output logic [1:0]        band_code
);
   localparam int NUM_TH = 3;
   localparam logic [31:0] BAND_TH [NUM_TH] = '{32'd75_000_000, 32'd125_000_000, 32'd175_000_000};

   if (IMP_W < 7) begin : g_imp_chk
      $error("phy_code_map: IMP_W must hold 100");
   end
   if (FREQ_W < 28 || FREQ_W > 32) begin : g_freq_chk
      $error("phy_code_map: FREQ_W must be 28..32");
   end

   always_comb begin
      if (imp_ohm == IMP_W'(33))       drv_code = 3'd1;
      else if (imp_ohm == IMP_W'(40))  drv_code = 3'd4;
      else if (imp_ohm == IMP_W'(66))  drv_code = 3'd2;
      else if (imp_ohm == IMP_W'(100)) drv_code = 3'd3;
      else                             drv_code = 3'd0;
   end

   logic [NUM_TH-1:0] at_or_above;
   for (genvar g = 0; g < NUM_TH; g++) begin : g_th
      assign at_or_above[g] = (freq_hz >= FREQ_W'(BAND_TH[g]));
   end

   logic [1:0] steps;
   always_comb begin
      steps = 2'd0;
      for (int k = 0; k < NUM_TH; k++) steps = steps + 2'(at_or_above[k]);
      band_code = (freq_hz == '0) ? 2'd0 : 2'(steps + 2'd1);
   end

endmodule

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
   import phy_bringup_pkg::*;
#(
   parameter int CYC_PER_US = 100,
   parameter int PD_WAIT_US = 3,
   parameter int CAL_GAP_US = 10,
   parameter int DLL_GAP_US = 10000,
   parameter int CAL_TRIES  = 5,
   parameter int DLL_TRIES  = 5,
   parameter int IMP_W      = 8,
   parameter int FREQ_W     = 32,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IMP_W-1:0]  imp_ohm,
   input  logic [FREQ_W-1:0] freq_hz,
   output logic              bus_wr,
   output logic              bus_rd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              done,
   output logic              cal_timeout,
   output logic              dll_timeout
);
   localparam int PD_CYC  = PD_WAIT_US * CYC_PER_US;
   localparam int CAL_CYC = CAL_GAP_US * CYC_PER_US;
   localparam int DLL_CYC = DLL_GAP_US * CYC_PER_US;
   localparam int MAX_CYC = (PD_CYC > CAL_CYC) ? ((PD_CYC > DLL_CYC) ? PD_CYC : DLL_CYC)
                                               : ((CAL_CYC > DLL_CYC) ? CAL_CYC : DLL_CYC);
   localparam int CW      = $clog2(MAX_CYC + 1);
   localparam int MAX_TRY = (CAL_TRIES > DLL_TRIES) ? CAL_TRIES : DLL_TRIES;
   localparam int TW      = $clog2(MAX_TRY + 1);

   if (CYC_PER_US < 1 || PD_WAIT_US < 1 || CAL_GAP_US < 1 || DLL_GAP_US < 1) begin : g_wait_chk
      $error("phy_bringup_seq: waits must be at least one cycle");
   end
   if (CAL_TRIES < 1 || DLL_TRIES < 1) begin : g_try_chk
      $error("phy_bringup_seq: retry limits must be positive");
   end
   if (ADDR_W < 6) begin : g_addr_chk
      $error("phy_bringup_seq: ADDR_W must reach offset 0x20");
   end

   seq_state_e state_q, state_d;
   logic [2:0]    drv_q;
   logic [1:0]    band_q;
   logic          fnz_q;
   logic [TW-1:0] tries_q;
   logic [2:0]    drv_map;
   logic [1:0]    band_map;
   logic          tmr_load, tmr_exp;
   logic [CW-1:0] tmr_val;
   logic          poll_hit, poll_last;

   phy_code_map #(.IMP_W(IMP_W), .FREQ_W(FREQ_W)) u_map (
      .imp_ohm   (imp_ohm),
      .freq_hz   (freq_hz),
      .drv_code  (drv_map),
      .band_code (band_map)
   );

   phy_wait_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   // the status bit under test depends on the poll phase
   logic [4:0] stat_idx;
   assign stat_idx  = (state_q == ST_DLL_CHK) ? 5'(STAT_DLL_BIT) : 5'(STAT_CAL_BIT);
   assign poll_hit  = bus_rdata[stat_idx];
   assign poll_last = (state_q == ST_DLL_CHK) ? (tries_q == TW'(DLL_TRIES - 1))
                                              : (tries_q == TW'(CAL_TRIES - 1));

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE:      if (start) state_d = ST_WR_DRV;
         ST_WR_DRV:    state_d = ST_WR_TAPEN;
         ST_WR_TAPEN:  state_d = ST_WR_TAPSEL;
         ST_WR_TAPSEL: state_d = ST_WR_PDOFF;
         ST_WR_PDOFF: begin
            state_d  = ST_WAIT_PD;
            tmr_load = 1'b1;
            tmr_val  = CW'(PD_CYC - 1);
         end
         ST_WAIT_PD:   if (tmr_exp) state_d = ST_WR_PDON;
         ST_WR_PDON:   state_d = ST_CAL_RD;
         ST_CAL_RD:    state_d = ST_CAL_CHK;
         ST_CAL_CHK: begin
            if (poll_hit || poll_last) state_d = ST_WR_BAND;
            else begin
               state_d  = ST_CAL_GAP;
               tmr_load = 1'b1;
               tmr_val  = CW'(CAL_CYC - 1);
            end
         end
         ST_CAL_GAP:   if (tmr_exp) state_d = ST_CAL_RD;
         ST_WR_BAND:   state_d = ST_WR_DLLEN;
         ST_WR_DLLEN:  state_d = fnz_q ? ST_DLL_RD : ST_FIN;
         ST_DLL_RD:    state_d = ST_DLL_CHK;
         ST_DLL_CHK: begin
            if (poll_hit || poll_last) state_d = ST_FIN;
            else begin
               state_d  = ST_DLL_GAP;
               tmr_load = 1'b1;
               tmr_val  = CW'(DLL_CYC - 1);
            end
         end
         ST_DLL_GAP:   if (tmr_exp) state_d = ST_DLL_RD;
         ST_FIN:       state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         drv_q       <= '0;
         band_q      <= '0;
         fnz_q       <= 1'b0;
         tries_q     <= '0;
         cal_timeout <= 1'b0;
         dll_timeout <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start) begin
            drv_q       <= drv_map;
            band_q      <= band_map;
            fnz_q       <= (freq_hz != '0);
            cal_timeout <= 1'b0;
            dll_timeout <= 1'b0;
         end
         if (state_q == ST_WR_PDON || state_q == ST_WR_DLLEN) tries_q <= '0;
         if ((state_q == ST_CAL_CHK || state_q == ST_DLL_CHK) && !poll_hit) begin
            if (poll_last) begin
               if (state_q == ST_CAL_CHK) cal_timeout <= 1'b1;
               else                       dll_timeout <= 1'b1;
            end else begin
               tries_q <= tries_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      bus_wr    = 1'b0;
      bus_rd    = 1'b0;
      bus_addr  = ADDR_W'(OFS_CTRL_A);
      bus_wdata = '0;
      unique case (state_q)
         ST_WR_DRV:    begin bus_wr = 1'b1; bus_addr = ADDR_W'(OFS_CTRL_B); bus_wdata = WM_DRV | {25'd0, drv_q, 4'd0}; end
         ST_WR_TAPEN:  begin bus_wr = 1'b1; bus_wdata = WD_TAP_EN; end
         ST_WR_TAPSEL: begin bus_wr = 1'b1; bus_wdata = WD_TAP_SEL4; end
         ST_WR_PDOFF:  begin bus_wr = 1'b1; bus_addr = ADDR_W'(OFS_CTRL_B); bus_wdata = WD_PD_DLL_0; end
         ST_WR_PDON:   begin bus_wr = 1'b1; bus_addr = ADDR_W'(OFS_CTRL_B); bus_wdata = WD_PD_ON; end
         ST_WR_BAND:   begin bus_wr = 1'b1; bus_wdata = WM_BAND | {18'd0, band_q, 12'd0}; end
         ST_WR_DLLEN:  begin bus_wr = 1'b1; bus_addr = ADDR_W'(OFS_CTRL_B); bus_wdata = WD_DLL_ON; end
         ST_CAL_RD, ST_DLL_RD: begin bus_rd = 1'b1; bus_addr = ADDR_W'(OFS_STAT); end
         default: ;
      endcase
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_FIN);

   AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> ((bus_wdata[15:0] & ~bus_wdata[31:16]) == 16'd0)); // R1
   AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd)); // R11
   AST_READ_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> (bus_addr == ADDR_W'(OFS_STAT))); // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable({cal_timeout, dll_timeout})); // R8
   AST_BUSY_START_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cal_timeout) |=> cal_timeout); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_wr && !bus_rd && !done)); // R10
   AST_NO_DLL_POLL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR_DLLEN && !fnz_q) |=> done); // R7

endmodule

// File: tb/phy_bringup_seq_bench.sv
module phy_bringup_seq_bench;
   localparam int CPU = 2;
   localparam int PDW = 3;
   localparam int CGU = 10;
   localparam int DGU = 20;
   localparam int NTR = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  imp_ohm = '0;
   logic [31:0] freq_hz = '0;
   logic        bus_wr, bus_rd, busy, done, cal_timeout, dll_timeout;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;

   always #10 clk = ~clk;

   phy_bringup_seq #(
      .CYC_PER_US(CPU), .PD_WAIT_US(PDW), .CAL_GAP_US(CGU), .DLL_GAP_US(DGU),
      .CAL_TRIES(NTR), .DLL_TRIES(NTR), .IMP_W(8), .FREQ_W(32), .ADDR_W(8)
   ) u_phy_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .imp_ohm(imp_ohm), .freq_hz(freq_hz),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .busy(busy), .done(done),
      .cal_timeout(cal_timeout), .dll_timeout(dll_timeout)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // bus log
   int          nw, ncal, ndll, ndone, overlap;
   logic [7:0]  wa [16];
   logic [31:0] wd [16];
   int          wc [16];
   int          cc [8];
   int          dc [8];
   bit          dll_ph;
   int          cal_pass, dll_pass;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
      if (bus_wr && bus_rd) overlap++;
      if (done) ndone++;
      if (bus_wr) begin
         if (nw < 16) begin wa[nw] = bus_addr; wd[nw] = bus_wdata; wc[nw] = cyc; end
         nw++;
         if (bus_addr == 8'h18 && bus_wdata == 32'h0002_0002) dll_ph = 1'b1;
      end
      if (bus_rd) begin
         if (!dll_ph) begin
            if (ncal < 8) cc[ncal] = cyc;
            ncal++;
            // bit 5 set as noise during calibration polling
            bus_rdata = 32'hA500_0020 | ((ncal >= cal_pass) ? 32'h40 : 32'h0);
         end else begin
            if (ndll < 8) dc[ndll] = cyc;
            ndll++;
            bus_rdata = 32'h5A00_0040 | ((ndll >= dll_pass) ? 32'h20 : 32'h0);
         end
      end
   end

   function automatic logic [2:0] exp_drv(input int ohm);
      case (ohm)
         33: return 3'd1;
         40: return 3'd4;
         66: return 3'd2;
         100: return 3'd3;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [1:0] exp_band(input logic [31:0] f);
      if (f == 0) return 2'd0;
      if (f < 75_000_000) return 2'd1;
      if (f < 125_000_000) return 2'd2;
      if (f < 175_000_000) return 2'd3;
      return 2'd0;
   endfunction

   task automatic run(input int ohm, input logic [31:0] f, input int cp, input int dp, input bit dbl);
      logic [31:0] ew [7];
      logic [7:0]  ea [7];
      int exp_cal, exp_dll, mg;
      bit ok;
      nw = 0; ncal = 0; ndll = 0; ndone = 0; dll_ph = 1'b0;
      cal_pass = cp; dll_pass = dp;
      imp_ohm = 8'(ohm); freq_hz = f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      imp_ohm = 8'd0; freq_hz = 32'd1;  // inputs change after start: must not matter
      chk("R8 flags cleared at start", {30'd0, cal_timeout, dll_timeout}, 32'd0);
      chk("R8 busy after start", {31'd0, busy}, 32'd1);
      if (dbl) begin
         repeat (20) @(negedge clk);
         imp_ohm = 8'd100; freq_hz = 32'd0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (ndone == 0) @(negedge clk);
      repeat (30) @(negedge clk);
      ea = '{8'h18, 8'h00, 8'h00, 8'h18, 8'h18, 8'h00, 8'h18};
      ew[0] = 32'h0070_0000 | {25'd0, exp_drv(ohm), 4'd0};
      ew[1] = 32'h0800_0800;
      ew[2] = 32'h0780_0200;
      ew[3] = 32'h0003_0000;
      ew[4] = 32'h0001_0001;
      ew[5] = 32'h3000_0000 | {18'd0, exp_band(f), 12'd0};
      ew[6] = 32'h0002_0002;
      chk(dbl ? "R9 write count with late start" : "R4 write count", nw, 32'd7);
      ok = 1'b1;
      for (int k = 0; k < 7; k++) if (wa[k] !== ea[k] || wd[k] !== ew[k]) ok = 1'b0;
      chk("R4 write order and words", {31'd0, ok}, 32'd1);
      chk("R2 drive code", wd[0], ew[0]);
      chk("R3 band code", wd[5], ew[5]);
      chk("R1 masked words", {16'd0, wd[0][15:0] & ~wd[0][31:16]} | {16'd0, wd[5][15:0] & ~wd[5][31:16]}, 32'd0);
      chk("R5 power-up wait", {31'd0, (wc[4] - wc[3]) >= PDW * CPU}, 32'd1);
      exp_cal = (cp <= NTR) ? cp : NTR;
      exp_dll = (f == 0) ? 0 : ((dp <= NTR) ? dp : NTR);
      chk("R6 calibration reads", ncal, exp_cal);
      chk("R6 cal_timeout", {31'd0, cal_timeout}, {31'd0, cp > NTR});
      mg = 1 << 20;
      for (int k = 1; k < ncal && k < 8; k++) if (cc[k] - cc[k-1] < mg) mg = cc[k] - cc[k-1];
      chk("R6 calibration gap", {31'd0, mg >= CGU * CPU}, 32'd1);
      chk("R7 dll reads", ndll, exp_dll);
      chk("R7 dll_timeout", {31'd0, dll_timeout}, {31'd0, (f != 0) && (dp > NTR)});
      mg = 1 << 20;
      for (int k = 1; k < ndll && k < 8; k++) if (dc[k] - dc[k-1] < mg) mg = dc[k] - dc[k-1];
      chk("R7 dll gap", {31'd0, mg >= DGU * CPU}, 32'd1);
      chk("R8 single done pulse", ndone, 32'd1);
      chk("R8 flags held while idle", {30'd0, cal_timeout, dll_timeout},
          {30'd0, cp > NTR, (f != 0) && (dp > NTR)});
      chk("R11 no read write overlap", overlap, 32'd0);
      chk("R8 idle after done", {31'd0, busy}, 32'd0);
   endtask

   initial begin
      logic [31:0] fl [10];
      int il [9];
      fl = '{32'd0, 32'd1, 32'd74_999_999, 32'd75_000_000, 32'd124_999_999,
             32'd125_000_000, 32'd174_999_999, 32'd175_000_000, 32'd200_000_000, 32'hFFFF_FFFF};
      il = '{33, 40, 50, 66, 100, 0, 34, 101, 255};
      overlap = 0;
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {26'd0, busy, done, bus_wr, bus_rd, cal_timeout, dll_timeout}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 idle after reset", {26'd0, busy, done, bus_wr, bus_rd, cal_timeout, dll_timeout}, 32'd0);
      for (int i = 0; i < 24; i++) begin
         run(il[i % 9], fl[i % 10], 1 + (i % 6), 1 + ((i + 3) % 6), i == 11 || i == 17);
      end
      // timeouts set, then a clean run must clear them
      run(50, 32'd100_000_000, 9, 9, 1'b0);
      run(66, 32'd100_000_000, 1, 1, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule